// File: doc/BRIEF.md
# Sequential Restoring / Non-Restoring Integer Divider

This block divides an unsigned WIDTH-bit dividend by an unsigned WIDTH-bit divisor. It works over several clock cycles and produces a WIDTH-bit quotient and a WIDTH-bit remainder. It holds three registers: a partial-remainder register that is one bit wider than the operands, so that its top bit acts as a sign, a quotient register that starts out holding the dividend, and a divisor register of the same widened size. A single adder/subtractor of WIDTH+1 bits serves both algorithms. The `mode_i` input, sampled when an operation is accepted, selects between them. In restoring mode the adder always subtracts, and a negative trial result is thrown away. In non-restoring mode the sign of the partial remainder picks add or subtract, and one extra correction addition may follow at the end.

A caller presents the operands and pulses `start_i`. `busy_o` stays high while the iterations run. `done_o` pulses for one cycle when the results are ready on `quotient_o` and `remainder_o`. The results are held until the next accepted start. A zero divisor is flagged on `div_zero_o` and finishes without iterating.

The control state machine has four states:
- IDLE waits for a start.
- ITER performs one shift-and-add/subtract step per cycle.
- FIX performs the non-restoring remainder correction.
- FINISH asserts `done_o`.

Its transitions are:
- IDLE→ITER: start accepted with a non-zero divisor.
- IDLE→FINISH: start accepted with a zero divisor.
- ITER→ITER: more steps remain.
- ITER→FIX: last step in non-restoring mode left a negative partial remainder.
- ITER→FINISH: last step otherwise.
- FIX→FINISH: always.
- FINISH→ITER or FINISH→FINISH: a new start is accepted in FINISH, with the same divisor test as in IDLE.
- FINISH→IDLE: no start.

Top module: `seq_divider`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `div_zero_o` are 0, and `quotient_o` and `remainder_o` are 0.
- R2: With `mode_i`=0 (restoring) and a non-zero divisor, the results at `done_o` satisfy `quotient_o` = dividend / divisor and `remainder_o` = dividend mod divisor.
- R3: With `mode_i`=1 (non-restoring) and a non-zero divisor, the results at `done_o` are the same floor quotient and non-negative remainder.
- R4: In restoring mode `done_o` is high exactly WIDTH clock edges after the edge that accepted the start.
- R5: In non-restoring mode `done_o` is high either WIDTH or WIDTH+1 clock edges after the accepting edge.
- R6: `done_o` is high for exactly one cycle per operation. `busy_o` is high from the accepting edge until `done_o` rises, and it is never high together with `done_o`.
- R7: A zero divisor sets `div_zero_o`, gives a quotient of all ones and a remainder equal to the dividend, and raises `done_o` on the cycle right after the accepting edge.
- R8: An accepted start with a non-zero divisor clears `div_zero_o`.
- R9: `start_i` is ignored while `busy_o` is high. The running operation finishes with the operands and mode it was started with.
- R10: After `done_o` the results and `div_zero_o` stay unchanged until the next accepted start.
- R11: Boundary operands give correct results in both modes. These include a divisor larger than the dividend, a divisor of 1, a dividend of 0, and both operands at their maximum value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin an operation (accepted in IDLE or FINISH) |
| mode_i | input | 1 | 0 = restoring, 1 = non-restoring |
| dividend_i | input | WIDTH | Unsigned dividend |
| divisor_i | input | WIDTH | Unsigned divisor |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| quotient_o | output | WIDTH | Quotient |
| remainder_o | output | WIDTH | Remainder |
| div_zero_o | output | 1 | Last accepted operation had a zero divisor |

## Verification
A wrong decision about a quotient bit, or a wrong choice between add and subtract, corrupts the partial remainder. The error then carries through every later step. It appears at the ports as a wrong quotient or remainder on the single `done_o` cycle, and it rarely cancels out over random operands.

A wrong step counter, or a missing or extra correction, appears as `done_o` arriving off the WIDTH or WIDTH+1 edge window. In non-restoring mode it also appears as an over-large or wrapped remainder. Comparing the two modes on the same random operand pairs exposes a fault that hits only one sign path.

// File: rtl/seq_div_pkg.sv
package seq_div_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ITER   = 2'd1,
        ST_FIX    = 2'd2,
        ST_FINISH = 2'd3
    } div_state_t;

    typedef enum logic {
        MODE_RESTORE    = 1'b0,
        MODE_NONRESTORE = 1'b1
    } div_mode_t;

endpackage

// File: rtl/seq_div_addsub.sv
module seq_div_addsub #(
    parameter int AW = 9
) (
    input  logic [AW-1:0] opa_i,
    input  logic [AW-1:0] opb_i,
    input  logic          sub_i,
    output logic [AW-1:0] sum_o
);
    logic [AW-1:0] opb_eff;

    always_comb begin
        opb_eff = opb_i ^ {AW{sub_i}};
        sum_o   = opa_i + opb_eff + {{(AW-1){1'b0}}, sub_i};
    end
endmodule

// File: rtl/seq_div_ctrl.sv
module seq_div_ctrl
    import seq_div_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic mode_i,
    input  logic divisor_zero_i,
    input  logic next_neg_i,
    output logic load_o,
    output logic load_zero_o,
    output logic step_o,
    output logic fix_o,
    output logic mode_o,
    output logic busy_o,
    output logic done_o
);
    localparam int CW = $clog2(WIDTH + 1);

    div_state_t state_q, state_d;
    logic [CW-1:0] cnt_q;
    div_mode_t mode_q;
    logic accept;
    logic last_step;

    assign accept    = start_i && (state_q == ST_IDLE || state_q == ST_FINISH);
    assign last_step = (cnt_q == CW'(1));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Step counter and latched mode
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            mode_q <= MODE_RESTORE;
        end else if (accept) begin
            cnt_q  <= CW'(WIDTH);
            mode_q <= div_mode_t'(mode_i);
        end else if (state_q == ST_ITER) begin
            cnt_q <= cnt_q - CW'(1);
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_FINISH: begin
                if (accept) begin
                    state_d = divisor_zero_i ? ST_FINISH : ST_ITER;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            ST_ITER: begin
                if (last_step) begin
                    if (mode_q == MODE_NONRESTORE && next_neg_i) begin
                        state_d = ST_FIX;
                    end else begin
                        state_d = ST_FINISH;
                    end
                end
            end
            ST_FIX: state_d = ST_FINISH;
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        load_o      = accept && !divisor_zero_i;
        load_zero_o = accept && divisor_zero_i;
        step_o      = 1'b0;
        fix_o       = 1'b0;
        busy_o      = 1'b0;
        done_o      = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_ITER:   begin step_o = 1'b1; busy_o = 1'b1; end
            ST_FIX:    begin fix_o  = 1'b1; busy_o = 1'b1; end
            ST_FINISH: done_o = 1'b1;
            default:   ;
        endcase
    end

    assign mode_o = mode_q;

    assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FINISH && !$past(accept)) |=> state_q != ST_FINISH || $past(accept));
    assert_busy_done_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && done_o));
    assert_cnt_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(WIDTH));
    assert_fix_only_nr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_FIX |-> mode_q == MODE_NONRESTORE);
    assert_iter_count_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_ITER |-> cnt_q != '0);
endmodule

// File: rtl/seq_div_datapath.sv
module seq_div_datapath #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             load_zero_i,
    input  logic             step_i,
    input  logic             fix_i,
    input  logic             mode_i,
    input  logic [WIDTH-1:0] dividend_i,
    input  logic [WIDTH-1:0] divisor_i,
    output logic             next_neg_o,
    output logic             acc_neg_o,
    output logic             div_zero_o,
    output logic [WIDTH-1:0] quotient_o,
    output logic [WIDTH-1:0] remainder_o
);
    localparam int AW = WIDTH + 1;

    logic [AW-1:0]    acc_q, acc_d;
    logic [WIDTH-1:0] quo_q, quo_d;
    logic [AW-1:0]    dvs_q;
    logic             dz_q;

    logic [AW-1:0]    acc_shift;
    logic [WIDTH-1:0] quo_shift;
    logic [AW-1:0]    alu_a;
    logic             alu_sub;
    logic [AW-1:0]    alu_sum;

    assign acc_shift = {acc_q[WIDTH-1:0], quo_q[WIDTH-1]};
    assign quo_shift = {quo_q[WIDTH-2:0], 1'b0};

    always_comb begin
        alu_a   = fix_i ? acc_q : acc_shift;
        alu_sub = 1'b1;
        if (fix_i) begin
            alu_sub = 1'b0;
        end else if (mode_i) begin
            alu_sub = !acc_q[AW-1];
        end
    end

    seq_div_addsub #(.AW(AW)) u_addsub (
        .opa_i (alu_a),
        .opb_i (dvs_q),
        .sub_i (alu_sub),
        .sum_o (alu_sum)
    );

    // Next-value selection for the step and the correction
    always_comb begin
        acc_d = acc_q;
        quo_d = quo_q;
        if (fix_i) begin
            acc_d = alu_sum;
        end else if (step_i) begin
            if (!mode_i && alu_sum[AW-1]) begin
                acc_d = acc_shift;
                quo_d = quo_shift;
            end else begin
                acc_d = alu_sum;
                quo_d = {quo_shift[WIDTH-1:1], ~alu_sum[AW-1]};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
            quo_q <= '0;
            dvs_q <= '0;
            dz_q  <= 1'b0;
        end else if (load_i) begin
            acc_q <= '0;
            quo_q <= dividend_i;
            dvs_q <= {1'b0, divisor_i};
            dz_q  <= 1'b0;
        end else if (load_zero_i) begin
            acc_q <= {1'b0, dividend_i};
            quo_q <= '1;
            dvs_q <= '0;
            dz_q  <= 1'b1;
        end else begin
            acc_q <= acc_d;
            quo_q <= quo_d;
        end
    end

    assign next_neg_o  = acc_d[AW-1];
    assign acc_neg_o   = acc_q[AW-1];
    assign div_zero_o  = dz_q;
    assign quotient_o  = quo_q;
    assign remainder_o = acc_q[WIDTH-1:0];

    assert_step_divisor_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |-> dvs_q != '0);
    assert_divisor_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && $past(step_i)) |-> $stable(dvs_q));
    assert_fix_makes_nonneg_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fix_i |=> !acc_q[AW-1]);
endmodule

// File: rtl/seq_divider.sv
module seq_divider #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             mode_i,
    input  logic [WIDTH-1:0] dividend_i,
    input  logic [WIDTH-1:0] divisor_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [WIDTH-1:0] quotient_o,
    output logic [WIDTH-1:0] remainder_o,
    output logic             div_zero_o
);
    logic load, load_zero, step, fix, mode_run, next_neg, acc_neg;
    logic divisor_zero;

    assign divisor_zero = (divisor_i == '0);

    seq_div_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .start_i        (start_i),
        .mode_i         (mode_i),
        .divisor_zero_i (divisor_zero),
        .next_neg_i     (next_neg),
        .load_o         (load),
        .load_zero_o    (load_zero),
        .step_o         (step),
        .fix_o          (fix),
        .mode_o         (mode_run),
        .busy_o         (busy_o),
        .done_o         (done_o)
    );

    seq_div_datapath #(.WIDTH(WIDTH)) u_dp (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (load),
        .load_zero_i (load_zero),
        .step_i      (step),
        .fix_i       (fix),
        .mode_i      (mode_run),
        .dividend_i  (dividend_i),
        .divisor_i   (divisor_i),
        .next_neg_o  (next_neg),
        .acc_neg_o   (acc_neg),
        .div_zero_o  (div_zero_o),
        .quotient_o  (quotient_o),
        .remainder_o (remainder_o)
    );

    assert_rem_nonneg_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !acc_neg);
    assert_zero_quotient_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && div_zero_o) |-> quotient_o == '1);
    assert_results_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i && !$past(start_i) && !$past(busy_o)) |-> $stable(quotient_o) && $stable(remainder_o));
endmodule

// File: tb/tb_seq_divider.sv
module tb_seq_divider;
    localparam int WIDTH = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic mode_i = 1'b0;
    logic [WIDTH-1:0] dividend_i = '0;
    logic [WIDTH-1:0] divisor_i = '0;
    logic busy_o, done_o, div_zero_o;
    logic [WIDTH-1:0] quotient_o, remainder_o;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    seq_divider #(.WIDTH(WIDTH)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .mode_i      (mode_i),
        .dividend_i  (dividend_i),
        .divisor_i   (divisor_i),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .quotient_o  (quotient_o),
        .remainder_o (remainder_o),
        .div_zero_o  (div_zero_o)
    );

    function automatic logic [WIDTH-1:0] exp_quo(input logic [WIDTH-1:0] a, input logic [WIDTH-1:0] b);
        return (b == '0) ? '1 : a / b;
    endfunction

    function automatic logic [WIDTH-1:0] exp_rem(input logic [WIDTH-1:0] a, input logic [WIDTH-1:0] b);
        return (b == '0) ? a : a % b;
    endfunction

    task automatic check(input bit ok, input string req, input int actual, input int expected);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    // Runs one operation; returns edges from acceptance to done
    task automatic run_op(input logic [WIDTH-1:0] a, input logic [WIDTH-1:0] b,
                          input logic m, input bit poke_busy, output int lat);
        logic [WIDTH-1:0] q_seen, r_seen;
        logic dz_seen;
        @(negedge clk);
        dividend_i = a; divisor_i = b; mode_i = m; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        lat = 0;
        if (b != '0) check(busy_o == 1'b1, "R6 busy after accept", busy_o, 1);
        if (poke_busy && b != '0) begin
            dividend_i = ~a; divisor_i = 8'd1; mode_i = ~m; start_i = 1'b1;
        end
        while (!done_o && lat < 4 * WIDTH) begin
            @(negedge clk);
            start_i = 1'b0;
            lat++;
        end
        check(done_o == 1'b1, "R6 done reached", done_o, 1);
        check(busy_o == 1'b0, "R6 busy low at done", busy_o, 0);
        if (m == 1'b0 || b == '0) begin
            check(quotient_o == exp_quo(a, b), (b == '0) ? "R7 quotient" : (poke_busy ? "R9 quotient" : "R2 quotient"),
                  quotient_o, exp_quo(a, b));
            check(remainder_o == exp_rem(a, b), (b == '0) ? "R7 remainder" : "R2 remainder",
                  remainder_o, exp_rem(a, b));
        end else begin
            check(quotient_o == exp_quo(a, b), poke_busy ? "R9 quotient" : "R3 quotient", quotient_o, exp_quo(a, b));
            check(remainder_o == exp_rem(a, b), "R3 remainder", remainder_o, exp_rem(a, b));
        end
        check(div_zero_o == (b == '0), (b == '0) ? "R7 flag" : "R8 flag", div_zero_o, int'(b == '0));
        if (b == '0) check(lat == 0, "R7 latency", lat, 0);
        else if (m == 1'b0) check(lat == WIDTH, "R4 latency", lat, WIDTH);
        else check(lat == WIDTH || lat == WIDTH + 1, "R5 latency", lat, WIDTH);
        q_seen = quotient_o; r_seen = remainder_o; dz_seen = div_zero_o;
        @(negedge clk);
        check(done_o == 1'b0, "R6 done single pulse", done_o, 0);
        repeat (2) @(negedge clk);
        check(quotient_o == q_seen && remainder_o == r_seen && div_zero_o == dz_seen,
              "R10 hold", quotient_o, q_seen);
    endtask

    initial begin
        int lat;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check(busy_o == 0 && done_o == 0 && div_zero_o == 0 && quotient_o == 0 && remainder_o == 0,
              "R1 reset state", {busy_o, done_o, div_zero_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy_o == 0 && done_o == 0 && quotient_o == 0, "R1 idle after reset", quotient_o, 0);

        // R11 boundary operands in both modes
        for (int m = 0; m < 2; m++) begin
            run_op(8'd11, 8'd13, 1'(m), 1'b0, lat);
            run_op(8'd13, 8'd11, 1'(m), 1'b0, lat);
            run_op(8'd0, 8'd7, 1'(m), 1'b0, lat);
            run_op(8'd200, 8'd1, 1'(m), 1'b0, lat);
            run_op(8'd255, 8'd255, 1'(m), 1'b0, lat);
            run_op(8'd255, 8'd1, 1'(m), 1'b0, lat);
            run_op(8'd254, 8'd255, 1'(m), 1'b0, lat);
            run_op(8'd128, 8'd3, 1'(m), 1'b0, lat);
        end
        // R7 zero divisor then R8 clear
        run_op(8'd77, 8'd0, 1'b0, 1'b0, lat);
        run_op(8'd77, 8'd5, 1'b1, 1'b0, lat);
        run_op(8'd0, 8'd0, 1'b1, 1'b0, lat);
        run_op(8'd9, 8'd2, 1'b0, 1'b0, lat);
        // R9 start while busy ignored
        run_op(8'd100, 8'd7, 1'b0, 1'b1, lat);
        run_op(8'd100, 8'd7, 1'b1, 1'b1, lat);

        // Random operands in both modes (R2, R3)
        for (int i = 0; i < 400; i++) begin
            logic [WIDTH-1:0] a, b;
            a = WIDTH'($urandom);
            b = WIDTH'($urandom);
            if (($urandom % 16) == 0) b = '0;
            run_op(a, b, 1'b0, 1'b0, lat);
            run_op(a, b, 1'b1, 1'b0, lat);
        end

        finished = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule